// File: doc/BRIEF.md
# Hex Code Digit Entry

This block builds a three-digit hexadecimal code from a four-bit switch value, one digit per key press. The digit key and the submit key are raw active-low levels. Each passes through a two-flop synchroniser and a press detector inside the block, so a key held down for any length of time acts once. Each accepted digit moves the code up by one nibble and takes the new digit in the low nibble. The code therefore always holds the last three digits typed.

Pressing the submit key copies the code as it stood before that press into a registered output and raises a valid flag for one cycle. A comparison controller downstream consumes that output. The code being typed is also shown on its own output, and a registered copy of the live switch value is given for display. A freeze input blocks both keys; only reset clears the state.

Top module: `hexpin_entry`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `entry_code` and `code_out` are zero and `code_valid` is low.
- R2: `sw_live` equals the value `sw_digit` had one clock edge earlier.
- R3: When `key_digit_n` goes low, `entry_code` changes at the third rising clock edge after that. The new value is the old code shifted left by 4 bits with `sw_digit` in bits 3:0.
- R4: Holding `key_digit_n` low for any number of cycles captures exactly one digit. Another capture needs the key to be released and pressed again.
- R5: After digits a, b, c are entered in that order, `entry_code` equals {a,b,c}, with a in bits 11:8. A fourth digit d gives {b,c,d}, and a is discarded.
- R6: When `key_submit_n` goes low, `code_valid` is high for exactly one cycle, starting at the third rising edge after that. In that cycle `code_out` equals the `entry_code` value from just before that edge. `code_out` holds its value until the next submit.
- R7: Holding `key_submit_n` low for many cycles produces exactly one `code_valid` pulse.
- R8: If `freeze` is high at the edge where a press would act, that press changes neither `entry_code` nor `code_out` and raises no `code_valid`. A key that is still held when `freeze` falls also does nothing.
- R9: If both keys are pressed in the same cycle, `code_out` receives the code from before the new digit, and `entry_code` takes the new digit.
- R10: Asserting `rst` partway through an entry clears `entry_code` and `code_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_digit | input | 4 | Digit value from switches |
| key_digit_n | input | 1 | Raw active-low key that confirms a digit |
| key_submit_n | input | 1 | Raw active-low key that submits the code |
| freeze | input | 1 | High blocks both keys |
| sw_live | output | 4 | Registered copy of the switch value |
| entry_code | output | 12 | Code being typed |
| code_out | output | 12 | Code presented on submit |
| code_valid | output | 1 | One-cycle flag that `code_out` is new |

## Verification
A key press takes effect three rising edges after the falling key level: two for the synchroniser and one for the capture register. `sw_live` follows the switches one edge later. The driver changes keys and switches just after a falling clock edge and holds each press for at least three cycles. It then reads `entry_code` at a falling edge, so a result is never sampled at the edge that makes it. Every submit pushes its predicted code into a queue. A monitor sampling at falling edges pops one entry for each `code_valid` it sees. A pulse that arrives when no entry is queued is reported as a failure, and so is an entry still queued at the end.

// File: rtl/hexpin_pkg.sv
package hexpin_pkg;
  // Index of each key within the key vector
  localparam int KEY_DIGIT  = 0;
  localparam int KEY_SUBMIT = 1;
  localparam int NUM_KEYS   = 2;
endpackage

// File: rtl/hexpin_key_edge.sv
module hexpin_key_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic key_n,
  output logic press
);
  logic [STAGES-1:0] sync_q;
  logic held, held_q;

  // Chain resets to the released level so reset never fakes a press
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[STAGES-2:0], key_n};
  end

  assign held = ~sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= held;
  end

  assign press = held & ~held_q;
endmodule

// File: rtl/hexpin_digit_reg.sv
module hexpin_digit_reg #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3,
  localparam int CODE_W    = DIGIT_W * NUM_DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [DIGIT_W-1:0] digit,
  output logic [CODE_W-1:0]  code
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)           code_q <= '0;
    else if (shift_en) code_q <= {code_q[CODE_W-DIGIT_W-1:0], digit};
  end

  assign code = code_q;
endmodule

// File: rtl/hexpin_submit.sv
module hexpin_submit #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= fire;
      if (fire) code_out <= code_in;
    end
  end
endmodule

// File: rtl/hexpin_entry.sv
module hexpin_entry #(
  parameter int DIGIT_W     = 4,
  parameter int NUM_DIGITS  = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = DIGIT_W * NUM_DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] sw_digit,
  input  logic               key_digit_n,
  input  logic               key_submit_n,
  input  logic               freeze,
  output logic [DIGIT_W-1:0] sw_live,
  output logic [CODE_W-1:0]  entry_code,
  output logic [CODE_W-1:0]  code_out,
  output logic               code_valid
);
  import hexpin_pkg::*;

  logic [NUM_KEYS-1:0] keys_n;
  logic [NUM_KEYS-1:0] press;
  logic [NUM_KEYS-1:0] act;

  assign keys_n[KEY_DIGIT]  = key_digit_n;
  assign keys_n[KEY_SUBMIT] = key_submit_n;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    hexpin_key_edge #(.STAGES(SYNC_STAGES)) edge_i (
      .clk   (clk),
      .rst   (rst),
      .key_n (keys_n[k]),
      .press (press[k])
    );
  end

  // The press detectors keep running while frozen, so a key held
  // across the end of a freeze does not act late
  assign act = freeze ? '0 : press;

  always_ff @(posedge clk) begin
    if (rst) sw_live <= '0;
    else     sw_live <= sw_digit;
  end

  hexpin_digit_reg #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) digits_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (act[KEY_DIGIT]),
    .digit    (sw_digit),
    .code     (entry_code)
  );

  hexpin_submit #(.CODE_W(CODE_W)) submit_i (
    .clk      (clk),
    .rst      (rst),
    .fire     (act[KEY_SUBMIT]),
    .code_in  (entry_code),
    .code_out (code_out),
    .valid    (code_valid)
  );
endmodule

// File: rtl/hexpin_entry_chk.sv
module hexpin_entry_chk #(
  parameter int DIGIT_W = 4,
  parameter int CODE_W  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] sw_digit,
  input logic               freeze,
  input logic [DIGIT_W-1:0] sw_live,
  input logic [CODE_W-1:0]  entry_code,
  input logic [CODE_W-1:0]  code_out,
  input logic               code_valid
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (entry_code == '0 && code_out == '0 && !code_valid));

  p_live_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sw_live == $past(sw_digit));

  p_shift_up_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && entry_code != $past(entry_code)) |->
      entry_code[CODE_W-1:DIGIT_W] == $past(entry_code[CODE_W-DIGIT_W-1:0]));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid);

  p_out_matches_r6: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !$past(rst)) |-> code_out == $past(entry_code));

  p_out_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!code_valid && !$past(rst)) |-> $stable(code_out));

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(freeze) && !$past(rst)) |-> ($stable(entry_code) && !code_valid));
endmodule

bind hexpin_entry hexpin_entry_chk #(.DIGIT_W(DIGIT_W), .CODE_W(CODE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sw_digit   (sw_digit),
  .freeze     (freeze),
  .sw_live    (sw_live),
  .entry_code (entry_code),
  .code_out   (code_out),
  .code_valid (code_valid)
);

// File: tb/hexpin_entry_tb_top.sv
module hexpin_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sw_digit = 4'h0;
  logic        key_digit_n = 1'b1;
  logic        key_submit_n = 1'b1;
  logic        freeze = 1'b0;
  logic [3:0]  sw_live;
  logic [11:0] entry_code;
  logic [11:0] code_out;
  logic        code_valid;

  int checks = 0;
  int bad = 0;
  int nvalid = 0;
  bit done = 0;
  logic [11:0] model = '0;
  logic [11:0] expq[$];

  always #5 clk = ~clk;

  hexpin_entry dut_i (
    .clk(clk), .rst(rst), .sw_digit(sw_digit),
    .key_digit_n(key_digit_n), .key_submit_n(key_submit_n),
    .freeze(freeze), .sw_live(sw_live), .entry_code(entry_code),
    .code_out(code_out), .code_valid(code_valid)
  );

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every valid pulse must match the next queued code
  always @(negedge clk) begin
    if (!rst && code_valid) begin
      nvalid++;
      if (expq.size() == 0) check(1'b0, "R6 unexpected valid", code_out, 12'h000);
      else begin
        logic [11:0] e;
        e = expq.pop_front();
        check(code_out == e, "R6 submitted code", code_out, e);
      end
    end
  end

  // Driver: press the chosen keys, predict the outcome, release
  task automatic press(input bit dig, input bit sub, input logic [3:0] d, input int hold);
    @(negedge clk);
    sw_digit = d;
    if (dig) key_digit_n = 1'b0;
    if (sub) key_submit_n = 1'b0;
    if (!freeze) begin
      if (sub) expq.push_back(model);
      if (dig) model = {model[7:0], d};
    end
    repeat (hold) @(negedge clk);
    key_digit_n = 1'b1;
    key_submit_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(entry_code == 12'h000, "R1 entry in reset", entry_code, 12'h000);
    check(code_out == 12'h000, "R1 code_out in reset", code_out, 12'h000);
    check(!code_valid, "R1 valid in reset", {11'b0, code_valid}, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    check(entry_code == 12'h000, "R1 entry after reset", entry_code, 12'h000);

    // R2: live switch copy one edge later
    sw_digit = 4'hA;
    @(negedge clk);
    check(sw_live == 4'hA, "R2 live value", {8'b0, sw_live}, 12'h00A);
    sw_digit = 4'h5;
    @(negedge clk);
    check(sw_live == 4'h5, "R2 live value", {8'b0, sw_live}, 12'h005);

    // R3 timing: unchanged after two edges, changed after the third
    @(negedge clk);
    sw_digit = 4'h1;
    key_digit_n = 1'b0;
    model = {model[7:0], 4'h1};
    repeat (2) @(negedge clk);
    check(entry_code == 12'h000, "R3 not before third edge", entry_code, 12'h000);
    @(negedge clk);
    check(entry_code == model, "R3 captured at third edge", entry_code, model);
    key_digit_n = 1'b1;
    repeat (4) @(negedge clk);

    press(1, 0, 4'h2, 3);
    check(entry_code == 12'h012, "R3 second digit", entry_code, 12'h012);
    press(1, 0, 4'h3, 3);
    check(entry_code == 12'h123, "R5 three digits", entry_code, 12'h123);
    press(1, 0, 4'hF, 3);
    check(entry_code == 12'h23F, "R5 oldest digit dropped", entry_code, 12'h23F);

    // R4: long hold captures one digit
    press(1, 0, 4'hC, 20);
    check(entry_code == 12'h3FC, "R4 long hold single capture", entry_code, 12'h3FC);

    // R6 / R7: submit, then a long submit hold
    press(0, 1, 4'h0, 3);
    check(nvalid == 1, "R6 one pulse", nvalid[11:0], 12'd1);
    press(0, 1, 4'h0, 25);
    check(nvalid == 2, "R7 long hold one pulse", nvalid[11:0], 12'd2);
    check(code_out == 12'h3FC, "R6 code_out holds", code_out, 12'h3FC);

    // R8: frozen presses do nothing
    freeze = 1'b1;
    press(1, 0, 4'h7, 3);
    check(entry_code == 12'h3FC, "R8 digit ignored when frozen", entry_code, 12'h3FC);
    press(0, 1, 4'h0, 3);
    check(nvalid == 2, "R8 submit ignored when frozen", nvalid[11:0], 12'd2);
    @(negedge clk);
    key_digit_n = 1'b0;
    repeat (5) @(negedge clk);
    freeze = 1'b0;
    repeat (6) @(negedge clk);
    check(entry_code == 12'h3FC, "R8 held key after unfreeze", entry_code, 12'h3FC);
    key_digit_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: both keys at once
    press(1, 1, 4'h9, 3);
    check(entry_code == 12'hFC9, "R9 entry takes digit", entry_code, 12'hFC9);
    check(code_out == 12'h3FC, "R9 code_out is pre-capture", code_out, 12'h3FC);
    check(nvalid == 3, "R9 one pulse", nvalid[11:0], 12'd3);

    // R10: reset partway through
    press(1, 0, 4'h4, 3);
    @(negedge clk);
    rst = 1'b1;
    model = '0;
    repeat (2) @(negedge clk);
    check(entry_code == 12'h000, "R10 entry cleared", entry_code, 12'h000);
    check(code_out == 12'h000, "R10 code_out cleared", code_out, 12'h000);
    rst = 1'b0;
    press(1, 0, 4'h8, 3);
    check(entry_code == 12'h008, "R10 fresh entry", entry_code, 12'h008);

    check(expq.size() == 0, "R6 queue drained", expq.size(), 12'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 12'h000, 12'h001);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule